// File: doc/BRIEF.md
# Vectored interrupt controller

This block gathers the interrupt lines of several devices into one request towards the processor. Any raised line arms the request, and the request stays up until the processor answers it, even if the device drops its line before then. The processor samples the request only at instruction boundaries. When it sees the request, it reads the controller's vector register. That read returns the start address of the service routine for the winning source, and the processor fetches its next instruction from that address.

Device lines are level sensitive. At the edge of the vector read, the controller samples the lines. The lowest-numbered asserted line wins, and its entry in a per-source vector table is latched into the read data. If no line is asserted at that edge, a default vector is returned instead. The vector table has one entry per source and is loaded through an address/data/write-enable port.

The sequencer has three states:
- `ST_IDLE`: no request is pending.
- `ST_PEND`: the request output is high.
- `ST_ACK`: a vector has just been read.

Its transitions:
- `ST_IDLE` to `ST_PEND` when a line is up.
- `ST_IDLE` or `ST_PEND` to `ST_ACK` on a read.
- `ST_ACK` to `ST_ACK` on another read.
- `ST_ACK` to `ST_IDLE` otherwise.

Top module: `vic_top`

## Requirements
- R1: From `ST_IDLE`, a clock edge that sees any `dev_irq` bit high (and no read) sets `irq_out` high from that edge on.
- R2: Once high, `irq_out` stays high until a vector read, even if every `dev_irq` line falls.
- R3: On a read edge, `vec_rdata` takes the table entry of the lowest-numbered asserted line (bit 0 of `dev_irq` is source 0 and has the highest priority), sampled at that edge.
- R4: On a read edge with no `dev_irq` bit high, `vec_rdata` takes `DEFAULT_VEC`.
- R5: Between reads, `vec_rdata` does not change, whatever the device lines or table writes do.
- R6: After a read edge, `irq_out` is low. It stays low for the cycle after that, and it rises again on the following edge only if a line is still high.
- R7: With `tbl_we` high, the edge writes `tbl_wdata` into entry `tbl_addr`. A read in that same cycle returns the entry's previous content.
- R8: Reset drives `irq_out` low, sets `vec_rdata` to `DEFAULT_VEC`, and loads every table entry with `DEFAULT_VEC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_irq | input | NUM_SRC | Level-sensitive device interrupt lines, bit 0 highest priority |
| vec_rd | input | 1 | Vector register read strobe from the processor |
| tbl_we | input | 1 | Vector table write enable |
| tbl_addr | input | IDX_W | Vector table entry selected for write |
| tbl_wdata | input | VEC_W | Vector value to write |
| irq_out | output | 1 | Combined interrupt request to the processor |
| vec_rdata | output | VEC_W | Latched interrupt vector returned by the read |

## Verification
Two pairs of events can meet in one cycle.

The first pair is a table write and a vector read that target the same entry. The bench raises that entry's line, writes a new value to the entry, and strobes the read in the same cycle. It expects the old value on the read. A second read must then return the new value.

The second pair is a line rising and a read arriving at the same edge while the controller is idle. That read must return the new source's vector, and `irq_out` must stay low through the acknowledge cycle.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_ACK  = 2'd2
    } vic_state_e;

endpackage

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] lines,
    output logic               hit,
    output logic [IDX_W-1:0]   idx
);

    // Scan from the top down so that the lowest index is written last and wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (lines[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vic_vec_table.sv
module vic_vec_table #(
    parameter int          NUM_SRC     = 8,
    parameter int          VEC_W       = 32,
    parameter logic [31:0] DEFAULT_VEC = 32'h0000_0100,
    localparam int         IDX_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [VEC_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [VEC_W-1:0] rdata
);

    logic [VEC_W-1:0] entry_q [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[g] <= VEC_W'(DEFAULT_VEC);
            end else if (we && (waddr == IDX_W'(g))) begin
                entry_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = entry_q[0];
        for (int i = 0; i < NUM_SRC; i++) begin
            if (raddr == IDX_W'(i)) begin
                rdata = entry_q[i];
            end
        end
    end

endmodule

// File: rtl/vic_fsm.sv
module vic_fsm
    import vic_pkg::*;
#(
    parameter int          VEC_W       = 32,
    parameter logic [31:0] DEFAULT_VEC = 32'h0000_0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_irq,
    input  logic             rd,
    input  logic             win_hit,
    input  logic [VEC_W-1:0] win_vec,
    output vic_state_e       state_q,
    output logic             irq_out,
    output logic [VEC_W-1:0] vec_q
);

    vic_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd) begin
                    state_d = ST_ACK;
                end else if (any_irq) begin
                    state_d = ST_PEND;
                end
            end
            ST_PEND: begin
                if (rd) begin
                    state_d = ST_ACK;
                end
            end
            ST_ACK: begin
                state_d = rd ? ST_ACK : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs: the request follows the state, and the vector is latched on a read
    always_comb begin
        irq_out = (state_q == ST_PEND);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= VEC_W'(DEFAULT_VEC);
        end else if (rd) begin
            vec_q <= win_hit ? win_vec : VEC_W'(DEFAULT_VEC);
        end
    end

endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int          NUM_SRC     = 8,
    parameter int          VEC_W       = 32,
    parameter logic [31:0] DEFAULT_VEC = 32'h0000_0100,
    localparam int         IDX_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] dev_irq,
    input  logic               vec_rd,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_addr,
    input  logic [VEC_W-1:0]   tbl_wdata,
    output logic               irq_out,
    output logic [VEC_W-1:0]   vec_rdata
);

    logic             win_hit;
    logic [IDX_W-1:0] win_idx;
    logic [VEC_W-1:0] win_vec;
    vic_state_e       state_q;

    vic_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
        .lines (dev_irq),
        .hit   (win_hit),
        .idx   (win_idx)
    );

    vic_vec_table #(
        .NUM_SRC     (NUM_SRC),
        .VEC_W       (VEC_W),
        .DEFAULT_VEC (DEFAULT_VEC)
    ) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_wdata),
        .raddr (win_idx),
        .rdata (win_vec)
    );

    vic_fsm #(
        .VEC_W       (VEC_W),
        .DEFAULT_VEC (DEFAULT_VEC)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_irq (win_hit),
        .rd      (vec_rd),
        .win_hit (win_hit),
        .win_vec (win_vec),
        .state_q (state_q),
        .irq_out (irq_out),
        .vec_q   (vec_rdata)
    );

endmodule

// File: rtl/vic_chk.sv
module vic_chk
    import vic_pkg::*;
#(
    parameter int          NUM_SRC     = 8,
    parameter int          VEC_W       = 32,
    parameter logic [31:0] DEFAULT_VEC = 32'h0000_0100
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] dev_irq,
    input logic               vec_rd,
    input logic               irq_out,
    input logic [VEC_W-1:0]   vec_rdata,
    input vic_state_e         state_q
);

    // R1
    irq_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && (|dev_irq) && !vec_rd) |=> irq_out);

    // R2
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !vec_rd) |=> irq_out);

    // R4
    default_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && dev_irq == '0) |=> (vec_rdata == VEC_W'(DEFAULT_VEC)));

    // R5
    vec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_rd |=> $stable(vec_rdata));

    // R6
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd |=> !irq_out);

    // R6
    irq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK) |=> !irq_out);

endmodule

bind vic_top vic_chk #(
    .NUM_SRC     (NUM_SRC),
    .VEC_W       (VEC_W),
    .DEFAULT_VEC (DEFAULT_VEC)
) u_vic_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_irq   (dev_irq),
    .vec_rd    (vec_rd),
    .irq_out   (irq_out),
    .vec_rdata (vec_rdata),
    .state_q   (state_q)
);

// File: tb/vic_top_bench.sv
module vic_top_bench;

    localparam int          NSRC = 8;
    localparam int          VW   = 32;
    localparam int          IW   = 3;
    localparam logic [31:0] DEF  = 32'h0000_0100;
    localparam int          NPAT = 10;
    localparam logic [7:0]  PAT [NPAT] = '{
        8'h01, 8'h80, 8'h0C, 8'hF0, 8'h00, 8'hFF, 8'h42, 8'h20, 8'h06, 8'h81
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NSRC-1:0] dev_irq = '0;
    logic           vec_rd = 1'b0;
    logic           tbl_we = 1'b0;
    logic [IW-1:0]  tbl_addr = '0;
    logic [VW-1:0]  tbl_wdata = '0;
    logic           irq_out;
    logic [VW-1:0]  vec_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vic_top u_vic_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_irq   (dev_irq),
        .vec_rd    (vec_rd),
        .tbl_we    (tbl_we),
        .tbl_addr  (tbl_addr),
        .tbl_wdata (tbl_wdata),
        .irq_out   (irq_out),
        .vec_rdata (vec_rdata)
    );

    function automatic logic [31:0] vec_of(int i);
        return 32'h1000_0000 + 32'(i) * 32'h40;
    endfunction

    function automatic logic [31:0] expect_vec(logic [7:0] l);
        for (int i = 0; i < NSRC; i++) begin
            if (l[i]) return vec_of(i);
        end
        return DEF;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_read();
        vec_rd = 1'b1;
        tick(1);
        vec_rd = 1'b0;
    endtask

    task automatic settle();
        dev_irq = '0;
        tick(3);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R8: reset state
        chk("R8 irq_out after reset", 32'(irq_out), 0);
        chk("R8 vec_rdata after reset", vec_rdata, DEF);
        dev_irq = 8'h10;
        tick(1);
        do_read();
        chk("R8 table entry reset to default", vec_rdata, DEF);
        settle();

        for (int i = 0; i < NSRC; i++) begin
            tbl_we = 1'b1;
            tbl_addr = IW'(i);
            tbl_wdata = vec_of(i);
            tick(1);
        end
        tbl_we = 1'b0;
        tick(1);

        // Pattern walk: R1, R3, R4, R6
        for (int p = 0; p < NPAT; p++) begin
            dev_irq = PAT[p];
            tick(1);
            chk("R1 irq_out follows lines", 32'(irq_out), 32'(|PAT[p]));
            do_read();
            chk("R3/R4 vector for pattern", vec_rdata, expect_vec(PAT[p]));
            chk("R6 irq_out low after read", 32'(irq_out), 0);
            settle();
        end

        // R2: request held after the line drops; R4 default on the read
        dev_irq = 8'h08;
        tick(1);
        dev_irq = '0;
        tick(5);
        chk("R2 irq_out held after line drop", 32'(irq_out), 1);
        do_read();
        chk("R4 default when no line at read", vec_rdata, DEF);
        chk("R2 irq_out released by read", 32'(irq_out), 0);
        settle();

        // R6: rearm after one quiet cycle when the line stays high
        dev_irq = 8'h04;
        tick(1);
        do_read();
        chk("R6 low right after read", 32'(irq_out), 0);
        tick(1);
        chk("R6 low in the gap cycle", 32'(irq_out), 0);
        tick(1);
        chk("R6 rearmed with line held", 32'(irq_out), 1);
        settle();
        do_read();
        settle();

        // R7: write and read of the same entry in one cycle
        dev_irq = 8'h04;
        tick(1);
        tbl_we = 1'b1;
        tbl_addr = 3'd2;
        tbl_wdata = 32'hCAFE_0200;
        vec_rd = 1'b1;
        tick(1);
        tbl_we = 1'b0;
        vec_rd = 1'b0;
        chk("R7 same-cycle read returns old entry", vec_rdata, vec_of(2));
        tick(1);
        do_read();
        chk("R7 next read returns new entry", vec_rdata, 32'hCAFE_0200);

        // R5: vector stable while lines and table change
        dev_irq = 8'h01;
        tbl_we = 1'b1;
        tbl_addr = 3'd2;
        tbl_wdata = 32'h1111_1111;
        tick(1);
        tbl_we = 1'b0;
        dev_irq = 8'h80;
        tick(4);
        chk("R5 vec_rdata unchanged without read", vec_rdata, 32'hCAFE_0200);
        settle();
        do_read();
        settle();

        // R3/R6: line rising at the same edge as a read from idle
        dev_irq = 8'h20;
        vec_rd = 1'b1;
        tick(1);
        vec_rd = 1'b0;
        chk("R3 read racing line rise", vec_rdata, vec_of(5));
        chk("R6 no request in ack cycle", 32'(irq_out), 0);
        settle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule